// File: doc/BRIEF.md
# Calibration pulse generator

This block produces the timing stimulus used to calibrate time-to-digital converters. One trigger starts a test cycle. The cycle opens with a short calibration-trigger marker. It then issues one or two test pulses and closes with a common-stop pulse. All times are counted in system clock ticks from the start of the cycle.

The settings are plain parallel inputs, and they are captured when a cycle is accepted:

- the trailing-edge time of the first test pulse, 20 bits;
- the time of the stop pulse, 20 bits;
- the test pulse width, 8 bits;
- a two-bit mode, which selects disabled, single-pulse or double-pulse operation.

In double-pulse mode a second test pulse of the same width is placed at the midpoint between the first pulse's trailing edge and the stop time. This exercises data-compaction logic downstream. A stop time that does not lie after the first pulse is flagged as a configuration error, and that cycle then emits no test pulse.

Top module: `cal_pulse_gen`

## Requirements
- R1: While reset is active and after its release, `busy_o`, `cal_trig_o`, `test_pulse_o`, `stop_pulse_o` and `cfg_err_o` are all low until a start is accepted.
- R2: A high `start_i` at a rising clock edge while idle is accepted. Cycle time t=0 is the clock period that follows that edge. `busy_o` is high from t=0 for exactly max(stop+10, 17) clocks and is low otherwise. Every output pulse lies inside that busy window.
- R3: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running cycle continues unchanged and no second marker appears.
- R4: `cal_trig_o` is high for t in [0, 17), which is 85 ns at a 5 ns clock.
- R5: In single mode (`mode_i` = 2'b01) and in double mode, `test_pulse_o` is high for t in [E-W, E). E is `p1_end_i`. W is `width_i`, raised to 10 when it is below 10. The leading edge saturates at 0 when E < W.
- R6: `stop_pulse_o` is high for t in [S, S+10), where S is `stop_i`.
- R7: In double mode (`mode_i` = 2'b10), `test_pulse_o` is also high for t in [M-W, M), where M = (E+S)>>1. Its leading edge saturates at 0, and a pulse that overlaps the first one merges with it.
- R8: When `mode_i` is 2'b00 or 2'b11, the cycle emits no test pulse. The marker and the stop pulse are still emitted.
- R9: When the mode is single or double and S <= E, `cfg_err_o` goes high at t=0 and that cycle emits no test pulse. The flag is held until the next accepted start, which recomputes it.
- R10: The settings are sampled only when a start is accepted. Changes to them during a cycle do not alter that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Test cycle trigger |
| mode_i | input | 2 | 00/11 disabled, 01 single, 10 double |
| p1_end_i | input | 20 | Trailing-edge time of the first test pulse |
| stop_i | input | 20 | Stop pulse time |
| width_i | input | 8 | Test pulse width in clocks |
| busy_o | output | 1 | High for the whole test cycle |
| cal_trig_o | output | 1 | Start-of-cycle marker |
| test_pulse_o | output | 1 | Test pulse(s) |
| stop_pulse_o | output | 1 | Common-stop pulse |
| cfg_err_o | output | 1 | Stop time not after the first pulse |

## Verification
A corrupted cycle counter or bound register shows up at once, as a test or stop pulse edge that moves by one or more clocks. The bench compares every clock of every cycle against the expected waveform, so such a fault is reported in the cycle where it occurs. A stuck run/idle state shows up as a wrong cycle length at the fall of `busy_o`, or as a second marker within a cycle. A stale error flag shows up at t=0 of the next cycle.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_ONE = 2'b01,
    MODE_TWO = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  localparam int NUM_WIN = 4;
  localparam int WIN_MARK = 0;
  localparam int WIN_P1 = 1;
  localparam int WIN_P2 = 2;
  localparam int WIN_STOP = 3;
endpackage

// File: rtl/cpg_window.sv
module cpg_window #(
  parameter int CW = 21
) (
  input  logic [CW-1:0] t_i,
  input  logic          en_i,
  input  logic [CW-1:0] lo_i,
  input  logic [CW-1:0] hi_i,
  output logic          hit_o
);
  // half-open interval [lo, hi)
  always_comb begin
    hit_o = en_i && (t_i >= lo_i) && (t_i < hi_i);
  end
endmodule

// File: rtl/cpg_plan.sv
module cpg_plan
  import cpg_pkg::*;
#(
  parameter int TIME_W = 20,
  parameter int WIDTH_W = 8,
  parameter int MIN_PW = 10,
  parameter int STOP_W = 10,
  parameter int MARK_W = 17,
  localparam int CW = TIME_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [1:0]         mode_i,
  input  logic [TIME_W-1:0]  end_i,
  input  logic [TIME_W-1:0]  stop_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic [CW-1:0]      p1_lo_o,
  output logic [CW-1:0]      p1_hi_o,
  output logic [CW-1:0]      p2_lo_o,
  output logic [CW-1:0]      p2_hi_o,
  output logic [CW-1:0]      stop_lo_o,
  output logic [CW-1:0]      stop_hi_o,
  output logic [CW-1:0]      last_o,
  output logic               p1_en_o,
  output logic               p2_en_o,
  output logic               err_o
);
  mode_e         mode;
  logic [CW-1:0] wide_end, wide_stop, w_raw, w_eff, mid, stop_end;
  logic          pulses_on, bad;
  logic [CW-1:0] p1_lo_d, p2_lo_d, last_d;
  logic          p1_en_d, p2_en_d;

  assign mode = mode_e'(mode_i);

  always_comb begin
    wide_end  = CW'(end_i);
    wide_stop = CW'(stop_i);
    w_raw     = CW'(width_i);
    w_eff     = (w_raw < CW'(MIN_PW)) ? CW'(MIN_PW) : w_raw;
    pulses_on = (mode == MODE_ONE) || (mode == MODE_TWO);
    bad       = pulses_on && (wide_stop <= wide_end);
    mid       = (wide_end + wide_stop) >> 1;
    p1_lo_d   = (wide_end > w_eff) ? (wide_end - w_eff) : '0;
    p2_lo_d   = (mid > w_eff) ? (mid - w_eff) : '0;
    stop_end  = wide_stop + CW'(STOP_W);
    last_d    = ((stop_end > CW'(MARK_W)) ? stop_end : CW'(MARK_W)) - CW'(1);
    p1_en_d   = pulses_on && !bad;
    p2_en_d   = (mode == MODE_TWO) && !bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_lo_o   <= '0;
      p1_hi_o   <= '0;
      p2_lo_o   <= '0;
      p2_hi_o   <= '0;
      stop_lo_o <= '0;
      stop_hi_o <= '0;
      last_o    <= '0;
      p1_en_o   <= 1'b0;
      p2_en_o   <= 1'b0;
      err_o     <= 1'b0;
    end else if (load_i) begin
      p1_lo_o   <= p1_lo_d;
      p1_hi_o   <= wide_end;
      p2_lo_o   <= p2_lo_d;
      p2_hi_o   <= mid;
      stop_lo_o <= wide_stop;
      stop_hi_o <= stop_end;
      last_o    <= last_d;
      p1_en_o   <= p1_en_d;
      p2_en_o   <= p2_en_d;
      err_o     <= bad;
    end
  end
endmodule

// File: rtl/cpg_seq.sv
module cpg_seq
  import cpg_pkg::*;
#(
  parameter int CW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] last_i,
  output logic          load_o,
  output logic          busy_o,
  output logic [CW-1:0] t_o
);
  state_e        state_q, state_d;
  logic [CW-1:0] t_q, t_d;

  always_comb begin
    state_d = state_q;
    t_d     = t_q;
    load_o  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_RUN;
          t_d     = '0;
        end
      end
      ST_RUN: begin
        if (t_q == last_i) begin
          state_d = ST_IDLE;
        end else begin
          t_d = t_q + CW'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      t_q     <= '0;
    end else begin
      state_q <= state_d;
      t_q     <= t_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign t_o    = t_q;
endmodule

// File: rtl/cpg_rst_sync.sv
module cpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen
  import cpg_pkg::*;
#(
  parameter int TIME_W = 20,
  parameter int WIDTH_W = 8,
  parameter int MARK_CLKS = 17,
  parameter int STOP_CLKS = 10,
  parameter int MIN_PW_CLKS = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [TIME_W-1:0]  p1_end_i,
  input  logic [TIME_W-1:0]  stop_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               busy_o,
  output logic               cal_trig_o,
  output logic               test_pulse_o,
  output logic               stop_pulse_o,
  output logic               cfg_err_o
);
  localparam int CW = TIME_W + 1;

  logic          rst_sync_n;
  logic          load, busy;
  logic [CW-1:0] t, last;
  logic [CW-1:0] p1_lo, p1_hi, p2_lo, p2_hi, stop_lo, stop_hi;
  logic          p1_en, p2_en, err;
  logic [CW-1:0] win_lo [NUM_WIN];
  logic [CW-1:0] win_hi [NUM_WIN];
  logic          win_en [NUM_WIN];
  logic [NUM_WIN-1:0] win_hit;

  cpg_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cpg_seq #(.CW(CW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .last_i  (last),
    .load_o  (load),
    .busy_o  (busy),
    .t_o     (t)
  );

  cpg_plan #(
    .TIME_W  (TIME_W),
    .WIDTH_W (WIDTH_W),
    .MIN_PW  (MIN_PW_CLKS),
    .STOP_W  (STOP_CLKS),
    .MARK_W  (MARK_CLKS)
  ) u_plan (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_i    (load),
    .mode_i    (mode_i),
    .end_i     (p1_end_i),
    .stop_i    (stop_i),
    .width_i   (width_i),
    .p1_lo_o   (p1_lo),
    .p1_hi_o   (p1_hi),
    .p2_lo_o   (p2_lo),
    .p2_hi_o   (p2_hi),
    .stop_lo_o (stop_lo),
    .stop_hi_o (stop_hi),
    .last_o    (last),
    .p1_en_o   (p1_en),
    .p2_en_o   (p2_en),
    .err_o     (err)
  );

  always_comb begin
    win_lo[WIN_MARK] = '0;
    win_hi[WIN_MARK] = CW'(MARK_CLKS);
    win_en[WIN_MARK] = 1'b1;
    win_lo[WIN_P1]   = p1_lo;
    win_hi[WIN_P1]   = p1_hi;
    win_en[WIN_P1]   = p1_en;
    win_lo[WIN_P2]   = p2_lo;
    win_hi[WIN_P2]   = p2_hi;
    win_en[WIN_P2]   = p2_en;
    win_lo[WIN_STOP] = stop_lo;
    win_hi[WIN_STOP] = stop_hi;
    win_en[WIN_STOP] = 1'b1;
  end

  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    cpg_window #(.CW(CW)) u_win (
      .t_i   (t),
      .en_i  (win_en[k]),
      .lo_i  (win_lo[k]),
      .hi_i  (win_hi[k]),
      .hit_o (win_hit[k])
    );
  end

  assign busy_o       = busy;
  assign cal_trig_o   = busy && win_hit[WIN_MARK];
  assign test_pulse_o = busy && (win_hit[WIN_P1] || win_hit[WIN_P2]);
  assign stop_pulse_o = busy && win_hit[WIN_STOP];
  assign cfg_err_o    = err;
endmodule

// File: rtl/cpg_checker.sv
module cpg_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic cal_trig_o,
  input logic test_pulse_o,
  input logic stop_pulse_o,
  input logic cfg_err_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(cal_trig_o || test_pulse_o || stop_pulse_o)); // R2

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o); // R2

  AST_MARK_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> cal_trig_o); // R4

  AST_NO_REMARK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !$past(cal_trig_o)) |-> !cal_trig_o); // R3

  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err_o && busy_o) |-> !test_pulse_o); // R9

  AST_STOP_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_pulse_o) |=> stop_pulse_o); // R6
endmodule

bind cal_pulse_gen cpg_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .cal_trig_o   (cal_trig_o),
  .test_pulse_o (test_pulse_o),
  .stop_pulse_o (stop_pulse_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/test_cal_pulse_gen.sv
`timescale 1ns/100ps
module test_cal_pulse_gen;
  localparam int TW = 20;
  localparam int WW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [TW-1:0] p_end = '0;
  logic [TW-1:0] p_stop = '0;
  logic [WW-1:0] width = '0;
  logic          busy, cal, tp, sp, err;

  always #2.5 clk = ~clk;

  cal_pulse_gen i_cal_pulse_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .mode_i       (mode),
    .p1_end_i     (p_end),
    .stop_i       (p_stop),
    .width_i      (width),
    .busy_o       (busy),
    .cal_trig_o   (cal),
    .test_pulse_o (tp),
    .stop_pulse_o (sp),
    .cfg_err_o    (err)
  );

  typedef struct {
    int m;
    int e;
    int s;
    int w;
  } item_t;

  item_t q_item[$];
  string q_tag[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  function automatic bit exp_err(item_t it);
    return (it.m == 1 || it.m == 2) && (it.s <= it.e);
  endfunction

  function automatic int exp_len(item_t it);
    return (it.s + 10 > 17) ? it.s + 10 : 17;
  endfunction

  // {cal, test, stop} at cycle time t
  function automatic logic [2:0] model(item_t it, int t);
    int w, lo1, lo2, mid;
    bit on1, on2, c, p, s;
    w   = (it.w < 10) ? 10 : it.w;
    on1 = (it.m == 1 || it.m == 2) && !exp_err(it);
    on2 = (it.m == 2) && !exp_err(it);
    lo1 = (it.e > w) ? it.e - w : 0;
    mid = (it.e + it.s) / 2;
    lo2 = (mid > w) ? mid - w : 0;
    c = (t < 17);
    p = (on1 && t >= lo1 && t < it.e) || (on2 && t >= lo2 && t < mid);
    s = (t >= it.s) && (t < it.s + 10);
    return {c, p, s};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run(int m, int e, int s, int w, string tag, int inject_at);
    item_t it;
    it.m = m; it.e = e; it.s = s; it.w = w;
    @(negedge clk);
    mode = m[1:0]; p_end = e[TW-1:0]; p_stop = s[TW-1:0]; width = w[WW-1:0];
    q_item.push_back(it);
    q_tag.push_back(tag);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject_at > 0) begin
      repeat (inject_at) @(negedge clk);
      // R3 R10: new start and new settings mid-cycle must change nothing
      mode = 2'b10; p_end = 20'd3; p_stop = 20'd7; width = 8'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    item_t cur;
    string tag;
    bit act, mis;
    int t, bad_t, got_v, exp_v;
    logic [2:0] e3;
    act = 0; mis = 0; t = 0; bad_t = 0; got_v = 0; exp_v = 0;
    cur.m = 0; cur.e = 0; cur.s = 0; cur.w = 0;
    tag = "R2";
    forever begin
      @(negedge clk);
      if (busy) begin
        if (!act) begin
          act = 1; t = 0; mis = 0;
          if (q_item.size() == 0) begin
            check(0, "R3", "cycle without accepted start", 1, 0);
          end else begin
            cur = q_item.pop_front();
            tag = q_tag.pop_front();
          end
          check(err == exp_err(cur), "R9", "cfg_err at t=0", int'(err), int'(exp_err(cur)));
        end
        e3 = model(cur, t);
        if ({cal, tp, sp} !== e3 && !mis) begin
          mis = 1; bad_t = t;
          got_v = int'({cal, tp, sp}); exp_v = int'(e3);
        end
        t++;
      end else if (act) begin
        act = 0;
        if (mis) $display("  first mismatch at t=%0d ({cal,test,stop})", bad_t);
        check(!mis, tag, "pulse waveform", got_v, exp_v);
        check(t == exp_len(cur), "R2", "busy length", t, exp_len(cur));
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check({busy, cal, tp, sp, err} == 5'b0, "R1", "outputs in reset", int'({busy, cal, tp, sp, err}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy, cal, tp, sp, err} == 5'b0, "R1", "outputs after reset", int'({busy, cal, tp, sp, err}), 0);

    run(1, 40, 100, 12, "R5", 0);       // single pulse
    run(2, 40, 120, 15, "R7", 0);       // double pulse, mid 80
    run(0, 30, 60, 12, "R8", 0);        // disabled
    run(3, 30, 60, 12, "R8", 0);        // reserved code also disabled
    run(1, 50, 90, 3, "R5", 0);         // width clamped to 10
    run(1, 5, 50, 20, "R5", 0);         // leading edge saturates
    run(2, 40, 40, 12, "R9", 0);        // stop not after pulse: error
    run(2, 40, 50, 20, "R7", 0);        // error cleared, overlapping pulses
    run(0, 1, 2, 10, "R4", 0);          // marker outlasts stop
    run(1, 60, 150, 10, "R10", 30);     // mid-cycle restart attempt
    run(2, 30000, 60000, 200, "R6", 0); // long times

    repeat (5) @(negedge clk);
    check(q_item.size() == 0, "R2", "all starts produced cycles", q_item.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule